// File: doc/BRIEF.md
# Configurable Pin Port with Peripheral Function Mux

This block is the core of one general-purpose I/O port, eight pins wide by default. Software sets it up through a small register bus with a write strobe and a combinational read port. For each pin it holds a direction bit, an output value bit, a pull-resistor enable bit, a drive-strength bit and a two-bit function code. Each function code is split across a low-select register and a high-select register. From these registers the block drives the pad controls: output value, output enable, pull-up, pull-down and high drive.

A pin can run as plain port I/O or carry one of three peripheral functions. In peripheral mode the output value comes from the chosen peripheral. The direction still comes from the direction register, unless the peripheral says it owns the direction, in which case it also supplies the output enable. Pad inputs pass through a two-flop synchronizer. The synchronized value feeds a read-only input register and a per-pin input towards the peripherals. That peripheral input freezes at its last value while the pin is back in port mode.

For an input pin with the pull enabled, the output-value bit selects pull-up or pull-down. Only pins marked in a build-time mask can switch to high drive.

Top module: `gpio_port_core`

## Requirements
- R1: In port mode (function code 0), a pin's output enable `padOe` equals its direction bit (register address 0). 1 means output and 0 means input.
- R2: Reading address 6 returns the pad level after two clock edges of synchronization. A write to address 6 changes nothing.
- R3: In port mode, `padOut` of a pin equals its output-value bit (address 1).
- R4: When the output enable of a pin is 0 and its pull-enable bit (address 2) is 1, the output-value bit selects the pull: 1 asserts `pullUp` and 0 asserts `pullDown`. A pin never has both pulls asserted, and never has a pull asserted while it drives.
- R5: With a pull-enable bit of 0, neither `pullUp` nor `pullDown` is asserted for that pin.
- R6: The function code of pin i is {bit i of address 5, bit i of address 4}. Code 0 is port I/O. Codes 1 to 3 drive `padOut[i]` from `periphOut[(code-1)*N + i]`.
- R7: In peripheral mode the output enable follows the direction bit. The exception is a pin whose `periphOwnDir` bit is 1: there `padOe` follows `periphOeReq`. In port mode `periphOwnDir` has no effect.
- R8: While a pin's function code is non-zero, `periphIn` of that pin equals the synchronized pad level. While the code is 0, `periphIn` holds the value it had in the last cycle before the code became 0.
- R9: `highDrive` equals the drive-strength register (address 3) ANDed with the high-drive-capable mask. The bit has no effect on other pins.
- R10: After reset every configuration register reads 0. This gives inputs, no pulls, port mode and regular drive, and `periphIn` is 0.
- R11: Addresses 0 to 5 read back the last value written. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | PIN_COUNT | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | PIN_COUNT | Read data (combinational) |
| pinIn | input | PIN_COUNT | Pad input levels |
| periphOut | input | 3*PIN_COUNT | Output values of peripheral functions 1..3, one slice per function |
| periphOwnDir | input | PIN_COUNT | Peripheral claims the direction of the pin |
| periphOeReq | input | PIN_COUNT | Output enable requested by the owning peripheral |
| periphIn | output | PIN_COUNT | Synchronized pin level for peripherals, held in port mode |
| padOut | output | PIN_COUNT | Pad output value |
| padOe | output | PIN_COUNT | Pad output enable |
| pullUp | output | PIN_COUNT | Pull-up enable |
| pullDown | output | PIN_COUNT | Pull-down enable |
| highDrive | output | PIN_COUNT | High drive strength enable |

## Verification
The assertions check four things on every cycle. The two pulls are never both on, and no pull is on while the pin drives. High drive stays inside the capable mask. The synchronized input lags the pads by exactly two edges. The peripheral input does not move while a pin stays in port mode. The other behaviour is covered only by the bench's scenarios. That covers the output value and enable chosen from every mix of direction, pull, function code and peripheral ownership, and the read-back map. It also covers the point at which the held peripheral value is captured when a pin returns to port mode.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [2:0] {
    SEL_DIR   = 3'd0,
    SEL_OUT   = 3'd1,
    SEL_PULL  = 3'd2,
    SEL_DRIVE = 3'd3,
    SEL_FLO   = 3'd4,
    SEL_FHI   = 3'd5,
    SEL_IN    = 3'd6,
    SEL_NONE  = 3'd7
  } regSel_t;

  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic wrPull;
    logic wrDrive;
    logic wrFuncLo;
    logic wrFuncHi;
  } cfgStrobe_t;

  localparam int FUNC_COUNT = 3;

endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output cfgStrobe_t        strobe,
  output regSel_t           rdSel
);

  function automatic regSel_t decodeAddr(input logic [ADDR_W-1:0] a);
    regSel_t s;
    s = SEL_NONE;
    for (int k = 0; k < 7; k++) begin
      if (a == ADDR_W'(k)) s = regSel_t'(k);
    end
    return s;
  endfunction

  regSel_t wrSel;

  always_comb begin
    wrSel           = decodeAddr(wrAddr);
    rdSel           = decodeAddr(rdAddr);
    strobe          = '0;
    strobe.wrDir    = wrEn && (wrSel == SEL_DIR);
    strobe.wrOut    = wrEn && (wrSel == SEL_OUT);
    strobe.wrPull   = wrEn && (wrSel == SEL_PULL);
    strobe.wrDrive  = wrEn && (wrSel == SEL_DRIVE);
    strobe.wrFuncLo = wrEn && (wrSel == SEL_FLO);
    strobe.wrFuncHi = wrEn && (wrSel == SEL_FHI);
  end

endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int                   PIN_COUNT       = 8,
  parameter logic [PIN_COUNT-1:0] HIGH_DRIVE_MASK = '1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cfgStrobe_t                     strobe,
  input  regSel_t                        rdSel,
  input  logic [PIN_COUNT-1:0]           wrData,
  output logic [PIN_COUNT-1:0]           rdData,
  input  logic [PIN_COUNT-1:0]           pinIn,
  input  logic [FUNC_COUNT*PIN_COUNT-1:0] periphOut,
  input  logic [PIN_COUNT-1:0]           periphOwnDir,
  input  logic [PIN_COUNT-1:0]           periphOeReq,
  output logic [PIN_COUNT-1:0]           periphIn,
  output logic [PIN_COUNT-1:0]           padOut,
  output logic [PIN_COUNT-1:0]           padOe,
  output logic [PIN_COUNT-1:0]           pullUp,
  output logic [PIN_COUNT-1:0]           pullDown,
  output logic [PIN_COUNT-1:0]           highDrive,
  output logic [PIN_COUNT-1:0]           funcLo,
  output logic [PIN_COUNT-1:0]           funcHi,
  output logic [PIN_COUNT-1:0]           inSync
);

  logic [PIN_COUNT-1:0] dirReg, outReg, pullReg, driveReg, funcLoReg, funcHiReg;
  logic [PIN_COUNT-1:0] syncStage, syncOut, holdReg, funcActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg    <= '0;
      outReg    <= '0;
      pullReg   <= '0;
      driveReg  <= '0;
      funcLoReg <= '0;
      funcHiReg <= '0;
      syncStage <= '0;
      syncOut   <= '0;
      holdReg   <= '0;
    end else begin
      if (strobe.wrDir)    dirReg    <= wrData;
      if (strobe.wrOut)    outReg    <= wrData;
      if (strobe.wrPull)   pullReg   <= wrData;
      if (strobe.wrDrive)  driveReg  <= wrData;
      if (strobe.wrFuncLo) funcLoReg <= wrData;
      if (strobe.wrFuncHi) funcHiReg <= wrData;
      syncStage <= pinIn;
      syncOut   <= syncStage;
      holdReg   <= periphIn;
    end
  end

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
    logic [1:0] code;
    logic       periphVal;
    assign code          = {funcHiReg[g], funcLoReg[g]};
    assign funcActive[g] = |code;

    always_comb begin
      case (code)
        2'd1:    periphVal = periphOut[g];
        2'd2:    periphVal = periphOut[PIN_COUNT + g];
        2'd3:    periphVal = periphOut[2*PIN_COUNT + g];
        default: periphVal = 1'b0;
      endcase
    end

    assign padOut[g]   = funcActive[g] ? periphVal : outReg[g];
    assign padOe[g]    = (funcActive[g] && periphOwnDir[g]) ? periphOeReq[g] : dirReg[g];
    assign pullUp[g]   = !padOe[g] && pullReg[g] && outReg[g];
    assign pullDown[g] = !padOe[g] && pullReg[g] && !outReg[g];
    assign periphIn[g] = funcActive[g] ? syncOut[g] : holdReg[g];
  end

  assign highDrive = driveReg & HIGH_DRIVE_MASK;
  assign funcLo    = funcLoReg;
  assign funcHi    = funcHiReg;
  assign inSync    = syncOut;

  always_comb begin
    case (rdSel)
      SEL_DIR:   rdData = dirReg;
      SEL_OUT:   rdData = outReg;
      SEL_PULL:  rdData = pullReg;
      SEL_DRIVE: rdData = driveReg;
      SEL_FLO:   rdData = funcLoReg;
      SEL_FHI:   rdData = funcHiReg;
      SEL_IN:    rdData = syncOut;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_core.sv
module gpio_port_core
  import gpio_pkg::*;
#(
  parameter int                   PIN_COUNT       = 8,
  parameter int                   ADDR_W          = 3,
  parameter logic [PIN_COUNT-1:0] HIGH_DRIVE_MASK = 8'b1100_0011
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic [PIN_COUNT-1:0]            wrData,
  input  logic [ADDR_W-1:0]               rdAddr,
  output logic [PIN_COUNT-1:0]            rdData,
  input  logic [PIN_COUNT-1:0]            pinIn,
  input  logic [FUNC_COUNT*PIN_COUNT-1:0] periphOut,
  input  logic [PIN_COUNT-1:0]            periphOwnDir,
  input  logic [PIN_COUNT-1:0]            periphOeReq,
  output logic [PIN_COUNT-1:0]            periphIn,
  output logic [PIN_COUNT-1:0]            padOut,
  output logic [PIN_COUNT-1:0]            padOe,
  output logic [PIN_COUNT-1:0]            pullUp,
  output logic [PIN_COUNT-1:0]            pullDown,
  output logic [PIN_COUNT-1:0]            highDrive
);

  cfgStrobe_t           strobe;
  regSel_t              rdSel;
  logic [PIN_COUNT-1:0] funcLo, funcHi, inSync;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  gpio_datapath #(
    .PIN_COUNT       (PIN_COUNT),
    .HIGH_DRIVE_MASK (HIGH_DRIVE_MASK)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .rdSel        (rdSel),
    .wrData       (wrData),
    .rdData       (rdData),
    .pinIn        (pinIn),
    .periphOut    (periphOut),
    .periphOwnDir (periphOwnDir),
    .periphOeReq  (periphOeReq),
    .periphIn     (periphIn),
    .padOut       (padOut),
    .padOe        (padOe),
    .pullUp       (pullUp),
    .pullDown     (pullDown),
    .highDrive    (highDrive),
    .funcLo       (funcLo),
    .funcHi       (funcHi),
    .inSync       (inSync)
  );

endmodule

// File: rtl/gpio_port_core_checker.sv
module gpio_port_core_checker #(
  parameter int                   PIN_COUNT       = 8,
  parameter logic [PIN_COUNT-1:0] HIGH_DRIVE_MASK = '1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [PIN_COUNT-1:0] pinIn,
  input logic [PIN_COUNT-1:0] padOe,
  input logic [PIN_COUNT-1:0] pullUp,
  input logic [PIN_COUNT-1:0] pullDown,
  input logic [PIN_COUNT-1:0] highDrive,
  input logic [PIN_COUNT-1:0] periphIn,
  input logic [PIN_COUNT-1:0] funcLo,
  input logic [PIN_COUNT-1:0] funcHi,
  input logic [PIN_COUNT-1:0] inSync
);

  logic [1:0]           upCycles;
  logic [PIN_COUNT-1:0] portIdle;

  assign portIdle = ~(funcLo | funcHi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCycles <= '0;
    else if (upCycles != 2) upCycles <= upCycles + 2'd1;
  end

  assert_pull_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pullUp & pullDown) == '0);

  assert_no_pull_when_driving_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((pullUp | pullDown) & padOe) == '0);

  assert_drive_in_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    (highDrive & ~HIGH_DRIVE_MASK) == '0);

  assert_sync_two_edges_R2: assert property (@(posedge clk) disable iff (!rstN)
    (upCycles == 2) |-> (inSync == $past(pinIn, 2)));

  assert_periph_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (upCycles != 0) |-> (((periphIn ^ $past(periphIn)) & portIdle & $past(portIdle)) == '0));

endmodule

bind gpio_port_core gpio_port_core_checker #(
  .PIN_COUNT       (PIN_COUNT),
  .HIGH_DRIVE_MASK (HIGH_DRIVE_MASK)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .pinIn     (pinIn),
  .padOe     (padOe),
  .pullUp    (pullUp),
  .pullDown  (pullDown),
  .highDrive (highDrive),
  .periphIn  (periphIn),
  .funcLo    (funcLo),
  .funcHi    (funcHi),
  .inSync    (inSync)
);

// File: tb/gpio_port_core_test.sv
module gpio_port_core_test;

  localparam int         N    = 8;
  localparam logic [7:0] MASK = 8'b1100_0011;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [2:0]   wrAddr = '0;
  logic [7:0]   wrData = '0;
  logic [2:0]   rdAddr = '0;
  logic [7:0]   rdData;
  logic [7:0]   pinIn = '0;
  logic [23:0]  periphOut = '0;
  logic [7:0]   periphOwnDir = '0;
  logic [7:0]   periphOeReq = '0;
  logic [7:0]   periphIn, padOut, padOe, pullUp, pullDown, highDrive;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_port_core #(.PIN_COUNT(N), .ADDR_W(3), .HIGH_DRIVE_MASK(MASK)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pinIn(pinIn), .periphOut(periphOut),
    .periphOwnDir(periphOwnDir), .periphOeReq(periphOeReq), .periphIn(periphIn),
    .padOut(padOut), .padOe(padOe), .pullUp(pullUp), .pullDown(pullDown),
    .highDrive(highDrive)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitEdges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    for (int a = 0; a < 6; a++) begin
      regRead(3'(a), rv);
      check($sformatf("R10 reset readback addr %0d", a), rv, 0);
    end
    check("R10 reset padOe", padOe, 0);
    check("R10 reset pulls", {pullUp, pullDown}, 0);
    check("R10 reset highDrive", highDrive, 0);
    check("R10 reset periphIn", periphIn, 0);

    // R11: readback of every config register, unmapped address
    for (int a = 0; a < 6; a++) regWrite(3'(a), 8'(8'h11 * (a + 3)));
    for (int a = 0; a < 6; a++) begin
      regRead(3'(a), rv);
      check($sformatf("R11 readback addr %0d", a), rv, 8'(8'h11 * (a + 3)));
    end
    regRead(3'd7, rv);
    check("R11 unmapped reads zero", rv, 0);

    // R9: drive strength masked by capability
    regWrite(3'd3, 8'hFF);
    check("R9 high drive all", highDrive, MASK);
    regWrite(3'd3, 8'h5A);
    check("R9 high drive pattern", highDrive, 8'h5A & MASK);

    // R2: two-edge synchronizer and read-only input register
    @(negedge clk); pinIn = 8'h5A;
    @(negedge clk);
    regRead(3'd6, rv);
    check("R2 input not yet visible after one edge", rv, 8'h00);
    @(negedge clk);
    regRead(3'd6, rv);
    check("R2 input visible after two edges", rv, 8'h5A);
    regWrite(3'd6, 8'hFF);
    regRead(3'd6, rv);
    check("R2 write to input register ignored", rv, 8'h5A);
    regRead(3'd0, rv);
    check("R2 write to input address leaves direction", rv, 8'h33);

    // R8: peripheral input follows then holds
    regWrite(3'd0, 8'h00);
    regWrite(3'd5, 8'h00);
    regWrite(3'd4, 8'h01);
    @(negedge clk); pinIn = 8'h01;
    waitEdges(3);
    check("R8 periphIn follows pin in function mode", periphIn[0], 1);
    regWrite(3'd4, 8'h00);
    @(negedge clk); pinIn = 8'h00;
    waitEdges(3);
    check("R8 periphIn held in port mode", periphIn[0], 1);
    regRead(3'd6, rv);
    check("R2 input register tracks pin in port mode", rv, 8'h00);
    regWrite(3'd4, 8'h01);
    check("R8 periphIn follows again after reselect", periphIn[0], 0);

    // R1 R3 R4 R5 R6 R7: near-exhaustive sweep of per-pin configurations
    periphOut = 24'hF0_3C_A5;
    for (int c = 0; c < 128; c++) begin
      logic [7:0] d, o, p, s0, s1, own, req;
      logic [7:0] eOut, eOe, eUp, eDn;
      for (int i = 0; i < N; i++) begin
        logic [6:0] cfg;
        cfg = 7'((c + i * 37) & 127);
        d[i] = cfg[0]; o[i] = cfg[1]; p[i] = cfg[2]; s0[i] = cfg[3];
        s1[i] = cfg[4]; own[i] = cfg[5]; req[i] = cfg[6];
      end
      regWrite(3'd0, d);
      regWrite(3'd1, o);
      regWrite(3'd2, p);
      regWrite(3'd4, s0);
      regWrite(3'd5, s1);
      periphOwnDir = own;
      periphOeReq  = req;
      #1;
      for (int i = 0; i < N; i++) begin
        int code;
        code    = {s1[i], s0[i]};
        eOe[i]  = (code != 0 && own[i]) ? req[i] : d[i];
        eOut[i] = (code == 0) ? o[i] : periphOut[(code - 1) * N + i];
        eUp[i]  = !eOe[i] && p[i] && o[i];
        eDn[i]  = !eOe[i] && p[i] && !o[i];
      end
      check($sformatf("R1/R3/R6/R7 cfg %0d out+oe", c), {padOut, padOe}, {eOut, eOe});
      check($sformatf("R4/R5 cfg %0d pulls", c), {pullUp, pullDown}, {eUp, eDn});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule